// File: doc/BRIEF.md
# One-Line Bus Slave Bit Engine

This block is the bit-level slave side of a single-slave, open-drain, one-line serial bus. It is fed the synchronised line level and a strobe that pulses once per microsecond, and it returns a single pull-down enable for the pad. From these it recognises a host bus reset and answers with a presence pulse. It also turns host write slots into received bits and answers host read slots from a byte queued by the layer above.

Received bits are gathered least significant bit first into bytes. Each complete byte comes with a one-cycle valid strobe. For the transmit direction the engine asks for a byte with a level request while transmit mode is selected. It then shifts that byte out, least significant bit first, one bit per read slot. Every recognised bus reset produces a one-cycle event, which command and accumulator logic above the engine use to abandon the transaction in progress. All timing values are parameters counted in microsecond strobes.

Top module: `ow_slave_engine`

## Requirements
- R1: Coming out of the synchronous reset, `pull_dn`, `bus_reset` and `rx_valid` are 0 and `tx_req` equals `tx_mode`.
- R2: A low line held for RESET_US (default 480) microsecond strobes produces exactly one single-cycle `bus_reset` pulse per low period, whatever the engine was doing, including mid-slot; no pulse appears before that count.
- R3: Once the line is high again after a bus reset, the engine waits PRES_WAIT_US (default 30) strobes and then asserts `pull_dn` for PRES_LEN_US (default 120) strobes.
- R4: With `tx_mode` = 0, a falling edge opens a write slot and the line level at the SAMPLE_US-th (default 30th) strobe after the edge is the received bit: high = 1, low = 0; the engine never drives the line in a write slot.
- R5: Eight received bits form a byte, the first bit in bit 0; `rx_byte` takes the byte and `rx_valid` is high for one cycle only.
- R6: With `tx_mode` = 1 and a queued bit of 0, `pull_dn` rises on the cycle after the falling edge is seen and falls at the RELEASE_US-th (default 30th) strobe; for a queued bit of 1, `pull_dn` stays low through the slot.
- R7: `tx_req` is high while `tx_mode` = 1 and no byte is queued; a `tx_load` pulse queues `tx_byte`, drops `tx_req`, and the byte's bits go out in read slots bit 0 first; after eight read slots `tx_req` returns high.
- R8: A read slot with no byte queued leaves the line undriven (the host reads 1) and consumes nothing, so `tx_req` stays high.
- R9: A `tx_load` while a byte is still queued is ignored; the queued byte goes out unchanged.
- R10: A bus reset discards a partly received byte and any queued transmit byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_us | input | 1 | One-cycle strobe once per microsecond |
| line_in | input | 1 | Synchronised level of the bus line |
| tx_mode | input | 1 | 1: slots are read slots answered by the engine; 0: write slots |
| tx_load | input | 1 | Queue `tx_byte` for transmission |
| tx_byte | input | BYTE_W | Byte to transmit, bit 0 sent first |
| pull_dn | output | 1 | Active-high enable of the pad pull-down |
| bus_reset | output | 1 | One-cycle pulse on a recognised bus reset |
| rx_byte | output | BYTE_W | Last complete received byte |
| rx_valid | output | 1 | One-cycle strobe when `rx_byte` is updated |
| tx_req | output | 1 | Level request for the next transmit byte |

## Verification
Write traffic uses the bytes A5h, 3Ch, FFh, 00h and 81h. Their alternating, paired, all-ones and all-zeros bit patterns separate a wrong shift direction, a wrong sample instant and a stuck bit. Read traffic uses 5Ah, 96h and 3Ch. The bench also probes the line inside a read-zero slot, just before and just after the release point. Long lows are issued from idle and while transmit mode and a partly received byte are pending. This separates a reset that clears state from one that only raises the event. The presence window is probed on both sides of each edge.

// File: rtl/ow_pkg.sv
package ow_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SLOT_WR,
        ST_SLOT_RD,
        ST_RECOVER,
        ST_RST_LOW,
        ST_PRES_WAIT,
        ST_PRES_DRIVE
    } ow_state_e;

    typedef struct packed {
        logic sample_stb;
        logic sample_bit;
        logic rd_start;
        logic rd_done;
    } slot_evt_t;

    function automatic int max_of3(input int a, input int b, input int c);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        return m;
    endfunction

endpackage

// File: rtl/ow_reset_detect.sv
module ow_reset_detect #(
    parameter int RESET_US = 480
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_us,
    input  logic line_in,
    output logic bus_rst
);
    localparam int CW = $clog2(RESET_US + 1);
    localparam logic [CW-1:0] LOW_LAST = CW'(RESET_US - 1);
    localparam logic [CW-1:0] LOW_SAT  = CW'(RESET_US);

    logic [CW-1:0] low_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_cnt <= '0;
            bus_rst <= 1'b0;
        end else begin
            bus_rst <= 1'b0;
            if (line_in) begin
                low_cnt <= '0;
            end else if (tick_us && low_cnt != LOW_SAT) begin
                low_cnt <= low_cnt + CW'(1);
                if (low_cnt == LOW_LAST) bus_rst <= 1'b1;
            end
        end
    end

    p_rst_single_r2: assert property (@(posedge clk) disable iff (rst)
        bus_rst |=> !bus_rst);
    p_rst_from_low_r2: assert property (@(posedge clk) disable iff (rst)
        bus_rst |-> $past(!line_in));

endmodule

// File: rtl/ow_slot_ctrl.sv
module ow_slot_ctrl
    import ow_pkg::*;
#(
    parameter int PRES_WAIT_US = 30,
    parameter int PRES_LEN_US  = 120,
    parameter int SAMPLE_US    = 30,
    parameter int RELEASE_US   = 30
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      tick_us,
    input  logic      line_in,
    input  logic      bus_rst,
    input  logic      tx_mode,
    input  logic      drive_zero,
    output logic      pull_dn,
    output slot_evt_t evt
);
    localparam int MAXV = max_of3(max_of3(PRES_WAIT_US, PRES_LEN_US, SAMPLE_US), RELEASE_US, 1);
    localparam int CW   = $clog2(MAXV + 1);
    localparam logic [CW-1:0] WAIT_LAST = CW'(PRES_WAIT_US - 1);
    localparam logic [CW-1:0] PRES_LAST = CW'(PRES_LEN_US - 1);
    localparam logic [CW-1:0] SAMP_LAST = CW'(SAMPLE_US - 1);
    localparam logic [CW-1:0] REL_LAST  = CW'(RELEASE_US - 1);

    ow_state_e     state;
    logic [CW-1:0] cnt;
    logic          line_q;
    logic          fall;

    assign fall = line_q && !line_in;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            line_q  <= 1'b1;
            pull_dn <= 1'b0;
            evt     <= '0;
        end else begin
            line_q <= line_in;
            evt    <= '0;
            if (bus_rst) begin
                state   <= ST_RST_LOW;
                cnt     <= '0;
                pull_dn <= 1'b0;
            end else begin
                unique case (state)
                    ST_IDLE: begin
                        if (fall) begin
                            cnt <= '0;
                            if (tx_mode) begin
                                state        <= ST_SLOT_RD;
                                pull_dn      <= drive_zero;
                                evt.rd_start <= 1'b1;
                            end else begin
                                state <= ST_SLOT_WR;
                            end
                        end
                    end
                    ST_SLOT_WR: begin
                        if (tick_us) begin
                            if (cnt == SAMP_LAST) begin
                                evt.sample_stb <= 1'b1;
                                evt.sample_bit <= line_in;
                                state          <= ST_RECOVER;
                            end else begin
                                cnt <= cnt + CW'(1);
                            end
                        end
                    end
                    ST_SLOT_RD: begin
                        if (tick_us) begin
                            if (cnt == REL_LAST) begin
                                pull_dn     <= 1'b0;
                                evt.rd_done <= 1'b1;
                                state       <= ST_RECOVER;
                            end else begin
                                cnt <= cnt + CW'(1);
                            end
                        end
                    end
                    ST_RECOVER: begin
                        if (line_in) state <= ST_IDLE;
                    end
                    ST_RST_LOW: begin
                        if (line_in) begin
                            state <= ST_PRES_WAIT;
                            cnt   <= '0;
                        end
                    end
                    ST_PRES_WAIT: begin
                        if (tick_us) begin
                            if (cnt == WAIT_LAST) begin
                                pull_dn <= 1'b1;
                                cnt     <= '0;
                                state   <= ST_PRES_DRIVE;
                            end else begin
                                cnt <= cnt + CW'(1);
                            end
                        end
                    end
                    ST_PRES_DRIVE: begin
                        if (tick_us) begin
                            if (cnt == PRES_LAST) begin
                                pull_dn <= 1'b0;
                                state   <= ST_RECOVER;
                            end else begin
                                cnt <= cnt + CW'(1);
                            end
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    p_wr_undriven_r4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SLOT_WR) |-> !pull_dn);
    p_rd_one_undriven_r6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && fall && tx_mode && !drive_zero && !bus_rst) |=> !pull_dn);
    p_rd_zero_driven_r6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && fall && tx_mode && drive_zero && !bus_rst) |=> pull_dn);
    p_pres_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        bus_rst |=> !pull_dn);

endmodule

// File: rtl/ow_rx_shift.sv
module ow_rx_shift #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_rst,
    input  logic              sample_stb,
    input  logic              sample_bit,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              rx_valid
);
    localparam int BW = $clog2(BYTE_W);
    localparam logic [BW-1:0] LAST_BIT = BW'(BYTE_W - 1);

    logic [BYTE_W-1:0] sr;
    logic [BW-1:0]     nbits;
    logic [BYTE_W-1:0] sr_next;

    assign sr_next = {sample_bit, sr[BYTE_W-1:1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            sr       <= '0;
            nbits    <= '0;
            rx_byte  <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (bus_rst) begin
                sr    <= '0;
                nbits <= '0;
            end else if (sample_stb) begin
                sr <= sr_next;
                if (nbits == LAST_BIT) begin
                    nbits    <= '0;
                    rx_byte  <= sr_next;
                    rx_valid <= 1'b1;
                end else begin
                    nbits <= nbits + BW'(1);
                end
            end
        end
    end

    p_valid_single_r5: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);
    p_valid_after_sample_r5: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> $past(sample_stb));

endmodule

// File: rtl/ow_tx_shift.sv
module ow_tx_shift #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_rst,
    input  logic              tx_mode,
    input  logic              tx_load,
    input  logic [BYTE_W-1:0] tx_byte,
    input  logic              rd_start,
    input  logic              rd_done,
    output logic              drive_zero,
    output logic              tx_req
);
    localparam int LW = $clog2(BYTE_W + 1);

    logic [BYTE_W-1:0] sr;
    logic [LW-1:0]     left;
    logic              full;
    logic              armed;

    assign drive_zero = full && !sr[0];
    assign tx_req     = tx_mode && !full;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr    <= '0;
            left  <= '0;
            full  <= 1'b0;
            armed <= 1'b0;
        end else if (bus_rst) begin
            full  <= 1'b0;
            armed <= 1'b0;
            left  <= '0;
        end else begin
            if (rd_start) armed <= full;
            if (rd_done) begin
                armed <= 1'b0;
                if (armed) begin
                    sr   <= sr >> 1;
                    left <= left - LW'(1);
                    if (left == LW'(1)) full <= 1'b0;
                end
            end else if (tx_load && !full) begin
                sr   <= tx_byte;
                left <= LW'(BYTE_W);
                full <= 1'b1;
            end
        end
    end

    p_load_accept_r7: assert property (@(posedge clk) disable iff (rst)
        (tx_load && !full && !rd_done && !bus_rst) |=> !tx_req);
    p_load_ignored_r9: assert property (@(posedge clk) disable iff (rst)
        (tx_load && full && !rd_done && !bus_rst) |=> $stable(sr));
    p_reset_drops_r10: assert property (@(posedge clk) disable iff (rst)
        bus_rst |=> !drive_zero);

endmodule

// File: rtl/ow_slave_engine.sv
module ow_slave_engine
    import ow_pkg::*;
#(
    parameter int BYTE_W       = 8,
    parameter int RESET_US     = 480,
    parameter int PRES_WAIT_US = 30,
    parameter int PRES_LEN_US  = 120,
    parameter int SAMPLE_US    = 30,
    parameter int RELEASE_US   = 30
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_us,
    input  logic              line_in,
    input  logic              tx_mode,
    input  logic              tx_load,
    input  logic [BYTE_W-1:0] tx_byte,
    output logic              pull_dn,
    output logic              bus_reset,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              rx_valid,
    output logic              tx_req
);
    slot_evt_t evt;
    logic      drive_zero;

    ow_reset_detect #(.RESET_US(RESET_US)) u_rstdet (
        .clk     (clk),
        .rst     (rst),
        .tick_us (tick_us),
        .line_in (line_in),
        .bus_rst (bus_reset)
    );

    ow_slot_ctrl #(
        .PRES_WAIT_US (PRES_WAIT_US),
        .PRES_LEN_US  (PRES_LEN_US),
        .SAMPLE_US    (SAMPLE_US),
        .RELEASE_US   (RELEASE_US)
    ) u_slot (
        .clk        (clk),
        .rst        (rst),
        .tick_us    (tick_us),
        .line_in    (line_in),
        .bus_rst    (bus_reset),
        .tx_mode    (tx_mode),
        .drive_zero (drive_zero),
        .pull_dn    (pull_dn),
        .evt        (evt)
    );

    ow_rx_shift #(.BYTE_W(BYTE_W)) u_rx (
        .clk        (clk),
        .rst        (rst),
        .bus_rst    (bus_reset),
        .sample_stb (evt.sample_stb),
        .sample_bit (evt.sample_bit),
        .rx_byte    (rx_byte),
        .rx_valid   (rx_valid)
    );

    ow_tx_shift #(.BYTE_W(BYTE_W)) u_tx (
        .clk        (clk),
        .rst        (rst),
        .bus_rst    (bus_reset),
        .tx_mode    (tx_mode),
        .tx_load    (tx_load),
        .tx_byte    (tx_byte),
        .rd_start   (evt.rd_start),
        .rd_done    (evt.rd_done),
        .drive_zero (drive_zero),
        .tx_req     (tx_req)
    );

    p_no_rx_on_reset_r10: assert property (@(posedge clk) disable iff (rst)
        bus_reset |=> !rx_valid);

endmodule

// File: tb/sim_ow_slave_engine.sv
module sim_ow_slave_engine;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_us = 1'b0;
    logic       host_low = 1'b0;
    logic       tx_mode = 1'b0;
    logic       tx_load = 1'b0;
    logic [7:0] tx_byte = '0;
    logic       line_in;
    logic       pull_dn, bus_reset, rx_valid, tx_req;
    logic [7:0] rx_byte;

    int n_chk = 0;
    int n_err = 0;
    int rst_pulses = 0;
    int div = 0;
    bit done = 1'b0;
    logic [7:0] exp_q[$];

    always #10 clk = ~clk;

    assign line_in = ~(host_low | pull_dn);

    ow_slave_engine u0 (
        .clk(clk), .rst(rst), .tick_us(tick_us), .line_in(line_in),
        .tx_mode(tx_mode), .tx_load(tx_load), .tx_byte(tx_byte),
        .pull_dn(pull_dn), .bus_reset(bus_reset), .rx_byte(rx_byte),
        .rx_valid(rx_valid), .tx_req(tx_req)
    );

    // four clocks per microsecond strobe
    always @(negedge clk) begin
        div     <= (div == 3) ? 0 : div + 1;
        tick_us <= (div == 3);
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // scoreboard monitor for received bytes
    always @(negedge clk) begin
        if (!rst && bus_reset) rst_pulses++;
        if (!rst && rx_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R5 unexpected byte", int'(rx_byte), 0);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                check(rx_byte == e, "R4 R5 rx byte", int'(rx_byte), int'(e));
            end
        end
    end

    task automatic us(input int n);
        repeat (4 * n) @(negedge clk);
    endtask

    task automatic host_reset();
        int base;
        base = rst_pulses;
        host_low = 1'b1;
        us(470);
        check(rst_pulses == base, "R2 early pulse", rst_pulses - base, 0);
        us(30);
        check(rst_pulses == base + 1, "R2 reset pulse", rst_pulses - base, 1);
        host_low = 1'b0;
        us(20);
        check(line_in == 1'b1, "R3 presence wait", int'(line_in), 1);
        us(40);
        check(line_in == 1'b0, "R3 presence start", int'(line_in), 0);
        us(80);
        check(line_in == 1'b0, "R3 presence hold", int'(line_in), 0);
        us(30);
        check(line_in == 1'b1, "R3 presence end", int'(line_in), 1);
        check(rst_pulses == base + 1, "R2 single pulse", rst_pulses - base, 1);
    endtask

    task automatic write_bit(input logic b);
        host_low = 1'b1;
        us(b ? 5 : 60);
        host_low = 1'b0;
        us(b ? 60 : 5);
    endtask

    task automatic write_byte(input logic [7:0] v);
        exp_q.push_back(v);
        for (int i = 0; i < 8; i++) write_bit(v[i]);
        us(2);
    endtask

    task automatic read_bit(output logic b);
        host_low = 1'b1;
        us(2);
        host_low = 1'b0;
        us(11);
        b = line_in;
        us(52);
    endtask

    task automatic read_byte(input logic [7:0] e, input string req);
        for (int i = 0; i < 8; i++) begin
            logic b;
            read_bit(b);
            check(b == e[i], req, int'(b), int'(e[i]));
        end
    endtask

    task automatic load(input logic [7:0] v);
        @(negedge clk);
        tx_byte = v;
        tx_load = 1'b1;
        @(negedge clk);
        tx_load = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        logic b;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(pull_dn == 1'b0, "R1 pull_dn", int'(pull_dn), 0);
        check(bus_reset == 1'b0, "R1 bus_reset", int'(bus_reset), 0);
        check(rx_valid == 1'b0, "R1 rx_valid", int'(rx_valid), 0);
        check(tx_req == 1'b0, "R1 tx_req", int'(tx_req), 0);
        us(5);

        host_reset();

        // R4 R5 write traffic
        write_byte(8'hA5);
        write_byte(8'h3C);
        write_byte(8'hFF);
        write_byte(8'h00);

        // R7 R8 transmit path
        tx_mode = 1'b1;
        @(negedge clk);
        check(tx_req == 1'b1, "R7 request when empty", int'(tx_req), 1);
        read_bit(b);
        check(b == 1'b1, "R8 empty slot reads one", int'(b), 1);
        check(tx_req == 1'b1, "R8 nothing consumed", int'(tx_req), 1);

        load(8'h5A);
        check(tx_req == 1'b0, "R7 request drops", int'(tx_req), 0);
        load(8'hFF); // R9 must be ignored
        // R6 read-zero timing on bit 0 of 5Ah
        host_low = 1'b1;
        us(2);
        host_low = 1'b0;
        us(23);
        check(line_in == 1'b0, "R6 held low before release", int'(line_in), 0);
        us(10);
        check(line_in == 1'b1, "R6 released", int'(line_in), 1);
        us(30);
        for (int i = 1; i < 8; i++) begin
            logic bb;
            read_bit(bb);
            check(bb == ((8'h5A >> i) & 1), "R7 R9 tx bit", int'(bb), int'((8'h5A >> i) & 1));
        end
        check(tx_req == 1'b1, "R7 request after byte", int'(tx_req), 1);

        load(8'h96);
        read_byte(8'h96, "R6 R7 tx byte 96");

        // R10 transmit discard
        load(8'hC3);
        for (int i = 0; i < 3; i++) read_bit(b);
        host_reset();
        check(tx_req == 1'b1, "R10 tx dropped", int'(tx_req), 1);
        load(8'h3C);
        read_byte(8'h3C, "R10 fresh tx byte");

        // R10 receive discard
        tx_mode = 1'b0;
        us(2);
        write_bit(1'b1);
        write_bit(1'b1);
        write_bit(1'b1);
        host_reset();
        write_byte(8'h81);
        us(5);
        check(exp_q.size() == 0, "R5 R10 all bytes seen", exp_q.size(), 0);

        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule